// File: doc/BRIEF.md
# Sensor Status and Error Output Aggregator

This block gathers the fault and event signals of a position sensor into one status view and turns that view into two active-low pins: an error line and a warning line. Event flags (power-down reset, preset-pin pulse, reboot) are sticky. They stay set until the host acknowledges them, either by writing zero to their bit or by issuing a status-clear command. Condition flags (amplitude out of range, magnet fault, configuration, counter, position, battery and startup faults) follow their sources. They are sampled every cycle and drop on their own once the cause is gone.

A small operating-mode machine tracks whether the device is held in reset, waiting for its configuration, running or asleep. It holds the error line active in every mode except running. An option input also routes the sticky events onto the error line. The warning line shows the battery early warning only while battery monitoring is on. The host reads the flags, the current mode and a fixed revision code through a combinational read port.

The mode machine has four states:
- MODE_RESET: a reset is active. It is entered from any state while `hold_rst` is high.
- MODE_BOOT: the configuration is not yet loaded. It is entered from MODE_RESET when the reset releases, and from MODE_RUN when `cfg_done` falls.
- MODE_RUN: normal operation. It is entered from MODE_BOOT when `cfg_done` rises, and from MODE_SLEEP when `sleep_req` falls.
- MODE_SLEEP: the device is asleep. It is entered from MODE_RUN while `sleep_req` is high.

Top module: `sensor_status_agg`

## Requirements
- R1: While and after `rst_n` is low, the mode is MODE_RESET (code 0). The power-down flag is set and the preset and reboot flags are clear, so register 0x48 reads 0x01. `err_n` is 0 with `err_oe` 1, and `wrn_n` is 1 with `wrn_oe` 0.
- R2: A one-cycle pulse on `ev_undervolt` sets power-down (0x48 bit 0). A pulse on `ev_preset` sets preset (bit 1). A pulse on `ev_reboot` sets reboot (bit 2). Each flag is visible on the clock edge that samples the pulse.
- R3: Sticky flags hold after their event ends. A write to 0x48 clears exactly the bits written as 0 and leaves the bits written as 1. `clr_cmd` clears all three flags.
- R4: When a set event and a clear (by write or by `clr_cmd`) hit the same flag in the same cycle, the flag ends up set.
- R5: `ampl_low` and `ampl_high` are live. They read at 0x4A bits 0 and 1 one edge after being sampled, always together with the amplitude error at 0x49 bit 5, and all of them drop one edge after the input returns low.
- R6: The magnet error (0x4A bit 2) is set only when `nomag_en` is high and amplitude low, amplitude high or `pos_err` is present.
- R7: Register 0x49 shows the live faults at these bit positions: bit 0 startup, bit 1 configuration, bit 2 counter, bit 3 position, bit 4 battery, bit 5 amplitude, bit 6 no-magnet latch, bit 7 analog startup. Any one of them drives `err_n` to 0 one edge after it is sampled.
- R8: The mode reads at 0x4A bits 5:4 (0 reset, 1 boot, 2 run, 3 sleep). `err_n` is 0 in every mode except MODE_RUN. The transitions between modes are the ones listed in the state descriptions above.
- R9: With `err_route` high (sampled one edge earlier), any set sticky flag drives `err_n` to 0. With `err_route` low, the sticky flags do not affect `err_n`.
- R10: `wrn_n` is 0 (with `wrn_oe` 1) only when `bat_warn` and `bat_mon_en` were both high at the previous edge. 0x4A bit 3 shows this gated warning. The warning never affects `err_n`.
- R11: Address 0x4C reads the revision code: 0x04 when `VARIANT_X` is 1, and 0x03 when it is 0.
- R12: Reads of unmapped addresses return 0. Writes to any address other than 0x48 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ev_undervolt | input | 1 | Deep undervoltage event pulse |
| ev_preset | input | 1 | Preset pin pulse |
| ev_reboot | input | 1 | Reboot event pulse |
| ampl_low | input | 1 | Signal amplitude below range |
| ampl_high | input | 1 | Signal amplitude above range |
| stup_err | input | 1 | Startup fault |
| cfg_err | input | 1 | Configuration fault |
| ctr_err | input | 1 | Counter fault |
| pos_err | input | 1 | Position consistency fault |
| bat_err | input | 1 | Battery fault |
| nomag_latch | input | 1 | Latched no-magnet fault |
| ana_stup_err | input | 1 | Analog startup fault |
| nomag_en | input | 1 | No-magnet detection enable |
| bat_warn | input | 1 | Battery early warning |
| bat_mon_en | input | 1 | Battery monitoring enable |
| cfg_done | input | 1 | Configuration fully loaded |
| sleep_req | input | 1 | Sleep state active |
| hold_rst | input | 1 | Reset condition active |
| err_route | input | 1 | Route sticky events to error line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| clr_cmd | input | 1 | Status-clear command strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| err_n | output | 1 | Error line, active low |
| err_oe | output | 1 | Error line pull-down enable |
| wrn_n | output | 1 | Warning line, active low |
| wrn_oe | output | 1 | Warning line pull-down enable |

## Verification
Every flag, the mode and both output lines are registered once. So every result is due one rising edge after the stimulus is sampled, and `rd_data` follows `rd_addr` within the same cycle. The bench drives inputs just after a rising edge, lets exactly one edge pass, and samples 1 ns later. It checks that sticky flags persist by taking further edges with the event low. Same-cycle races between set and clear are applied within a single cycle, so the outcome is decided by one edge.

// File: rtl/status_agg_pkg.sv
package status_agg_pkg;

    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_BOOT  = 2'd1,
        MODE_RUN   = 2'd2,
        MODE_SLEEP = 2'd3
    } mode_e;

    localparam int unsigned STICKY_N  = 3;
    localparam int unsigned FAULT_N   = 8;

    localparam int unsigned STK_PDR   = 0;
    localparam int unsigned STK_PRE   = 1;
    localparam int unsigned STK_RBT   = 2;

    localparam logic [7:0] ADDR_STICKY = 8'h48;
    localparam logic [7:0] ADDR_FAULT  = 8'h49;
    localparam logic [7:0] ADDR_LIVE   = 8'h4A;
    localparam logic [7:0] ADDR_REV    = 8'h4C;

endpackage

// File: rtl/stat_mode_fsm.sv
module stat_mode_fsm
    import status_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold_rst_i,
    input  logic  cfg_done_i,
    input  logic  sleep_i,
    output mode_e mode_o,
    output logic  force_err_o
);

    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RESET: if (!hold_rst_i) mode_d = MODE_BOOT;
            MODE_BOOT: begin
                if (hold_rst_i)      mode_d = MODE_RESET;
                else if (cfg_done_i) mode_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (hold_rst_i)       mode_d = MODE_RESET;
                else if (!cfg_done_i) mode_d = MODE_BOOT;
                else if (sleep_i)     mode_d = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (hold_rst_i)    mode_d = MODE_RESET;
                else if (!sleep_i) mode_d = MODE_RUN;
            end
            default: mode_d = MODE_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_o      = mode_q;
        force_err_o = (mode_q != MODE_RUN);
    end

    // R8
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BOOT && !cfg_done_i && !hold_rst_i) |=> (mode_q == MODE_BOOT));

    // R8
    reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst_i |=> (mode_q == MODE_RESET));

endmodule

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
    parameter int unsigned       N       = 3,
    parameter logic [N-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[g] <= RST_VAL[g];
            else if (set_i[g]) flag_q[g] <= 1'b1;
            else if (clr_i[g]) flag_q[g] <= 1'b0;
        end

        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_q[g]);

        // R3
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[g]) |-> $past(clr_i[g]));
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/stat_live_cond.sv
module stat_live_cond
    import status_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ampl_low_i,
    input  logic               ampl_high_i,
    input  logic               stup_i,
    input  logic               cfg_i,
    input  logic               ctr_i,
    input  logic               pos_i,
    input  logic               bat_i,
    input  logic               nomag_latch_i,
    input  logic               ana_stup_i,
    input  logic               nomag_en_i,
    input  logic               bat_warn_i,
    input  logic               bat_mon_en_i,
    input  logic               route_i,
    output logic [FAULT_N-1:0] fault_o,
    output logic               ampl_low_o,
    output logic               ampl_high_o,
    output logic               mag_err_o,
    output logic               bat_wrn_o,
    output logic               route_o
);

    logic [FAULT_N-1:0] fault_d;
    logic [FAULT_N-1:0] fault_q;
    logic               low_q, high_q, mag_q, wrn_q, route_q;

    always_comb begin
        fault_d    = '0;
        fault_d[0] = stup_i;
        fault_d[1] = cfg_i;
        fault_d[2] = ctr_i;
        fault_d[3] = pos_i;
        fault_d[4] = bat_i;
        fault_d[5] = ampl_low_i | ampl_high_i;
        fault_d[6] = nomag_latch_i;
        fault_d[7] = ana_stup_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= '0;
            low_q   <= 1'b0;
            high_q  <= 1'b0;
            mag_q   <= 1'b0;
            wrn_q   <= 1'b0;
            route_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
            low_q   <= ampl_low_i;
            high_q  <= ampl_high_i;
            mag_q   <= nomag_en_i & (ampl_low_i | ampl_high_i | pos_i);
            wrn_q   <= bat_warn_i & bat_mon_en_i;
            route_q <= route_i;
        end
    end

    assign fault_o     = fault_q;
    assign ampl_low_o  = low_q;
    assign ampl_high_o = high_q;
    assign mag_err_o   = mag_q;
    assign bat_wrn_o   = wrn_q;
    assign route_o     = route_q;

    // R5
    ampl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q | high_q) |-> fault_q[5]);

    // R6
    mag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mag_q |-> $past(nomag_en_i));

endmodule

// File: rtl/sensor_status_agg.sv
module sensor_status_agg
    import status_agg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter bit          VARIANT_X = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_undervolt,
    input  logic              ev_preset,
    input  logic              ev_reboot,
    input  logic              ampl_low,
    input  logic              ampl_high,
    input  logic              stup_err,
    input  logic              cfg_err,
    input  logic              ctr_err,
    input  logic              pos_err,
    input  logic              bat_err,
    input  logic              nomag_latch,
    input  logic              ana_stup_err,
    input  logic              nomag_en,
    input  logic              bat_warn,
    input  logic              bat_mon_en,
    input  logic              cfg_done,
    input  logic              sleep_req,
    input  logic              hold_rst,
    input  logic              err_route,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_n,
    output logic              err_oe,
    output logic              wrn_n,
    output logic              wrn_oe
);

    localparam logic [DATA_W-1:0] REV_CODE = VARIANT_X ? DATA_W'(8'h04) : DATA_W'(8'h03);
    localparam logic [STICKY_N-1:0] STK_RST = STICKY_N'(1) << STK_PDR;

    mode_e              mode;
    logic               force_err;
    logic [STICKY_N-1:0] stk_set, stk_clr, stk_flags;
    logic [FAULT_N-1:0] faults;
    logic               low_f, high_f, mag_f, wrn_f, route_f;
    logic               wr_sticky;
    logic               err_act;
    logic               unused_ok;

    stat_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_rst_i  (hold_rst),
        .cfg_done_i  (cfg_done),
        .sleep_i     (sleep_req),
        .mode_o      (mode),
        .force_err_o (force_err)
    );

    always_comb begin
        stk_set          = '0;
        stk_set[STK_PDR] = ev_undervolt;
        stk_set[STK_PRE] = ev_preset;
        stk_set[STK_RBT] = ev_reboot;
        wr_sticky        = wr_en && (wr_addr == ADDR_W'(ADDR_STICKY));
        if (clr_cmd)        stk_clr = '1;
        else if (wr_sticky) stk_clr = ~wr_data[STICKY_N-1:0];
        else                stk_clr = '0;
    end

    stat_sticky_bank #(
        .N       (STICKY_N),
        .RST_VAL (STK_RST)
    ) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (stk_set),
        .clr_i   (stk_clr),
        .flags_o (stk_flags)
    );

    stat_live_cond u_live (
        .clk           (clk),
        .rst_n         (rst_n),
        .ampl_low_i    (ampl_low),
        .ampl_high_i   (ampl_high),
        .stup_i        (stup_err),
        .cfg_i         (cfg_err),
        .ctr_i         (ctr_err),
        .pos_i         (pos_err),
        .bat_i         (bat_err),
        .nomag_latch_i (nomag_latch),
        .ana_stup_i    (ana_stup_err),
        .nomag_en_i    (nomag_en),
        .bat_warn_i    (bat_warn),
        .bat_mon_en_i  (bat_mon_en),
        .route_i       (err_route),
        .fault_o       (faults),
        .ampl_low_o    (low_f),
        .ampl_high_o   (high_f),
        .mag_err_o     (mag_f),
        .bat_wrn_o     (wrn_f),
        .route_o       (route_f)
    );

    always_comb begin
        err_act = force_err | (|faults) | (route_f & (|stk_flags));
        err_n   = ~err_act;
        err_oe  = err_act;
        wrn_n   = ~wrn_f;
        wrn_oe  = wrn_f;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(ADDR_STICKY): rd_data = DATA_W'(stk_flags);
            ADDR_W'(ADDR_FAULT):  rd_data = DATA_W'(faults);
            ADDR_W'(ADDR_LIVE):   rd_data = DATA_W'({mode, wrn_f, mag_f, high_f, low_f});
            ADDR_W'(ADDR_REV):    rd_data = REV_CODE;
            default:              rd_data = '0;
        endcase
    end

    assign unused_ok = ^wr_data;

    // R8
    forced_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RUN) |-> (err_oe && !err_n));

    // R10
    warn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrn_oe |-> $past(bat_mon_en));

    // R9
    route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && faults == '0 && !route_f) |-> err_n);

endmodule

// File: tb/sensor_status_agg_bench.sv
`timescale 1ns/1ps
module sensor_status_agg_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_undervolt = 0, ev_preset = 0, ev_reboot = 0;
    logic ampl_low = 0, ampl_high = 0;
    logic stup_err = 0, cfg_err = 0, ctr_err = 0, pos_err = 0, bat_err = 0;
    logic nomag_latch = 0, ana_stup_err = 0, nomag_en = 0;
    logic bat_warn = 0, bat_mon_en = 0, cfg_done = 0, sleep_req = 0;
    logic hold_rst = 0, err_route = 0, wr_en = 0, clr_cmd = 0;
    logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
    logic [7:0] rd_data;
    logic err_n, err_oe, wrn_n, wrn_oe;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    sensor_status_agg u_sensor_status_agg (
        .clk(clk), .rst_n(rst_n),
        .ev_undervolt(ev_undervolt), .ev_preset(ev_preset), .ev_reboot(ev_reboot),
        .ampl_low(ampl_low), .ampl_high(ampl_high),
        .stup_err(stup_err), .cfg_err(cfg_err), .ctr_err(ctr_err), .pos_err(pos_err),
        .bat_err(bat_err), .nomag_latch(nomag_latch), .ana_stup_err(ana_stup_err),
        .nomag_en(nomag_en), .bat_warn(bat_warn), .bat_mon_en(bat_mon_en),
        .cfg_done(cfg_done), .sleep_req(sleep_req), .hold_rst(hold_rst),
        .err_route(err_route), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_cmd(clr_cmd), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_n(err_n), .err_oe(err_oe), .wrn_n(wrn_n), .wrn_oe(wrn_oe)
    );

    // columns: fault inputs {ana,nomag,ampl_low,bat,pos,ctr,cfg,stup}, err_n, 0x49
    localparam logic [16:0] VEC [10] = '{
        {8'h00, 1'b1, 8'h00},
        {8'h01, 1'b0, 8'h01},
        {8'h02, 1'b0, 8'h02},
        {8'h04, 1'b0, 8'h04},
        {8'h08, 1'b0, 8'h08},
        {8'h10, 1'b0, 8'h10},
        {8'h20, 1'b0, 8'h20},
        {8'h40, 1'b0, 8'h40},
        {8'h80, 1'b0, 8'h80},
        {8'h00, 1'b1, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp, input logic [7:0] mask);
        rd_addr = a;
        #1;
        chk(tag, rd_data & mask, exp);
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) tick();
        chk("R1 err_n", {7'd0, err_n}, 8'd0);
        chk("R1 err_oe", {7'd0, err_oe}, 8'd1);
        chk("R1 wrn", {6'd0, wrn_n, wrn_oe}, 8'b10);
        rd(8'h48, "R1 sticky", 8'h01, 8'hFF);
        rd(8'h4A, "R1 mode", 8'h00, 8'h30);
        rst_n = 1'b1;
        tick();
        rd(8'h4A, "R8 boot", 8'h10, 8'h30);
        chk("R8 boot err", {7'd0, err_n}, 8'd0);
        tick();
        rd(8'h4A, "R8 boot stays", 8'h10, 8'h30);
        cfg_done = 1;
        tick();
        rd(8'h4A, "R8 run", 8'h20, 8'h30);
        chk("R9 route off", {7'd0, err_n}, 8'd1);
        err_route = 1;
        tick();
        chk("R9 route on", {7'd0, err_n}, 8'd0);
        wr_en = 1; wr_addr = 8'h48; wr_data = 8'hFE;
        tick();
        wr_en = 0;
        rd(8'h48, "R3 write clear", 8'h00, 8'hFF);
        chk("R9 cleared", {7'd0, err_n}, 8'd1);

        // R7 vector walk
        for (int i = 0; i < 10; i++) begin
            {ana_stup_err, nomag_latch, ampl_low, bat_err, pos_err, ctr_err, cfg_err, stup_err} = VEC[i][16:9];
            tick();
            chk($sformatf("R7 err_n vec%0d", i), {7'd0, err_n}, {7'd0, VEC[i][8]});
            rd(8'h49, $sformatf("R7 faults vec%0d", i), VEC[i][7:0], 8'hFF);
        end

        // R2/R3 sticky events
        ev_preset = 1; tick(); ev_preset = 0;
        rd(8'h48, "R2 preset", 8'h02, 8'hFF);
        chk("R9 preset routed", {7'd0, err_n}, 8'd0);
        tick(); tick();
        rd(8'h48, "R3 preset holds", 8'h02, 8'hFF);
        ev_reboot = 1; tick(); ev_reboot = 0;
        rd(8'h48, "R2 reboot", 8'h06, 8'hFF);
        wr_en = 1; wr_addr = 8'h48; wr_data = 8'hFB; tick(); wr_en = 0;
        rd(8'h48, "R3 clear one bit", 8'h02, 8'hFF);
        wr_en = 1; wr_addr = 8'h47; wr_data = 8'h00; tick(); wr_en = 0;
        rd(8'h48, "R12 other addr write", 8'h02, 8'hFF);
        clr_cmd = 1; tick(); clr_cmd = 0;
        rd(8'h48, "R3 clr cmd", 8'h00, 8'hFF);
        ev_undervolt = 1; tick(); ev_undervolt = 0;
        rd(8'h48, "R2 undervolt", 8'h01, 8'hFF);
        clr_cmd = 1; tick(); clr_cmd = 0;

        // R4 set wins
        ev_undervolt = 1; clr_cmd = 1; tick(); ev_undervolt = 0; clr_cmd = 0;
        rd(8'h48, "R4 set vs cmd", 8'h01, 8'hFF);
        ev_reboot = 1; wr_en = 1; wr_addr = 8'h48; wr_data = 8'hFB; tick();
        ev_reboot = 0; wr_en = 0;
        rd(8'h48, "R4 set vs write", 8'h05, 8'hFF);
        clr_cmd = 1; tick(); clr_cmd = 0;
        err_route = 0; tick();

        // R5/R6 amplitude and magnet
        ampl_high = 1; tick();
        rd(8'h4A, "R5 high", 8'h02, 8'h0F);
        rd(8'h49, "R5 ampl err", 8'h20, 8'hFF);
        nomag_en = 1; tick();
        rd(8'h4A, "R6 mag set", 8'h06, 8'h0F);
        ampl_high = 0; tick();
        rd(8'h4A, "R5 self clear", 8'h00, 8'h0F);
        rd(8'h49, "R5 ampl err clear", 8'h00, 8'hFF);
        pos_err = 1; tick();
        rd(8'h4A, "R6 pos mag", 8'h04, 8'h0F);
        nomag_en = 0; tick();
        rd(8'h4A, "R6 mag disabled", 8'h00, 8'h0F);
        pos_err = 0; tick();
        chk("R7 idle err_n", {7'd0, err_n}, 8'd1);

        // R10 warning
        bat_warn = 1; tick();
        chk("R10 unmonitored", {6'd0, wrn_n, wrn_oe}, 8'b10);
        bat_mon_en = 1; tick();
        chk("R10 warn", {6'd0, wrn_n, wrn_oe}, 8'b01);
        chk("R10 err untouched", {7'd0, err_n}, 8'd1);
        rd(8'h4A, "R10 status", 8'h08, 8'h0F);
        bat_warn = 0; bat_mon_en = 0; tick();

        // R8 modes
        sleep_req = 1; tick();
        rd(8'h4A, "R8 sleep", 8'h30, 8'h30);
        chk("R8 sleep err", {7'd0, err_n}, 8'd0);
        sleep_req = 0; tick();
        chk("R8 wake err", {7'd0, err_n}, 8'd1);
        hold_rst = 1; tick();
        rd(8'h4A, "R8 reset mode", 8'h00, 8'h30);
        chk("R8 reset err", {7'd0, err_n}, 8'd0);
        hold_rst = 0; tick();
        rd(8'h4A, "R8 reset to boot", 8'h10, 8'h30);
        tick();
        rd(8'h4A, "R8 boot to run", 8'h20, 8'h30);
        cfg_done = 0; tick();
        rd(8'h4A, "R8 run to boot", 8'h10, 8'h30);

        // R11/R12 read map
        rd(8'h4C, "R11 revision", 8'h03, 8'hFF);
        rd(8'h50, "R12 unmapped", 8'h00, 8'hFF);
        rd(8'h4B, "R12 gap", 8'h00, 8'hFF);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule